// File: doc/BRIEF.md
# Selectable Read Output Pipeline Stage

This block is the read-data output path of a synchronous burst memory. A command arrives each clock cycle and the block captures it in an input register. In the cycle after a read is captured, the memory core presents that read's word on `core_rdata`. The block turns this into the value for the data pads, `dq_out`, and a drive enable, `dq_drive`, which the pad ring uses to control its tri-state buffers.

Two static mode inputs select the timing. `mode_flow` chooses between two paths. When it is set, the core word goes straight to the pads (flow-through). When it is clear, the word passes through a rising-edge output register (pipelined). `mode_dcd` chooses how fast the pads release after a deselect. With single-cycle release, the drivers turn off as soon as the deselect has been captured. With dual-cycle release, the deselect moves through the pipeline with the same latency as a read. A write command always releases the bus so that the data lines can be driven from outside. The active-low output enable `oe_n` gates the drivers with no clock involved. When both mode inputs are tied low, the block runs in its default mode: pipelined with single-cycle release.

Top module: `rop_read_out_path`

## Requirements
- R1: While reset is asserted, and after it is released until a read has reached the output, `dq_drive` is 0.
- R2: Flow-through mode (`mode_flow`=1) works as follows. A read captured at clock edge k drives `dq_drive`=1 between edges k and k+1, with `dq_out` equal to `core_rdata` of that cycle. The first word is therefore sampled at the second edge after the command is presented (2-1-1-1).
- R3: Pipelined mode (`mode_flow`=0) works as follows. A read captured at edge k drives `dq_out` between edges k+1 and k+2 with the `core_rdata` value held just before edge k+1. The first word is therefore sampled at the third edge (3-1-1-1).
- R4: In both modes, back-to-back reads give one new word per cycle with no gap and in issue order.
- R5: Pipelined mode with single-cycle release (`mode_dcd`=0) works as follows. A deselect captured at edge k+1, directly after a read captured at edge k, turns `dq_drive` off from edge k+1 on.
- R6: Pipelined mode with dual-cycle release (`mode_dcd`=1) works as follows. In the same sequence as R5, the last read word stays driven until edge k+2 and is released after that edge.
- R7: In flow-through mode a captured deselect releases the pads in the same cycle, whatever the value of `mode_dcd`.
- R8: A captured write (`cmd`=2'b10) forces `dq_drive`=0 in every mode. This includes a pipelined read that would otherwise still be on the pads.
- R9: `oe_n`=1 forces `dq_drive`=0 at once, also in the middle of a cycle. When `oe_n` returns to 0 without a clock edge, the previous drive state comes back.
- R10: Command encoding is 2'b00 deselect, 2'b01 read, 2'b10 write, and 2'b11 also deselect. Mode value 0 on both inputs gives the default mode: pipelined with single-cycle release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_flow | input | 1 | 1 = flow-through, 0 = pipelined (default) |
| mode_dcd | input | 1 | 1 = dual-cycle release, 0 = single-cycle release (default) |
| cmd | input | 2 | Command for this cycle: 00/11 deselect, 01 read, 10 write |
| core_rdata | input | DATA_W | Core word for the read held in the input register |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | DATA_W | Data toward the pad drivers |
| dq_drive | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
The checker evaluates the following on every clock edge:
- the output enable overrides the drive enable;
- a write releases the bus;
- the flow-through path returns the current core word one edge after the read;
- the pipelined path returns the core word sampled one edge earlier;
- a single-cycle deselect releases the pads at once, and a dual-cycle deselect keeps them driven one more cycle.

Some behaviour can only be shown by the bench scenarios. These cover the reset state, gap-free word order across whole bursts in each of the four mode combinations, the treatment of the 2'b11 code, and a change of `oe_n` in the middle of a cycle with no clock edge between the change and the check.

// File: rtl/rop_pkg.sv
// Shared types for the read output path.
// Assumes a two-bit command code; any code other than read or write counts as a deselect.
package rop_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_SPARE = 2'b11
    } rop_cmd_e;

    // Decoded contents of one pipeline slot
    typedef struct packed {
        logic rd;
        logic wr;
        logic off;
    } rop_slot_t;

    localparam rop_slot_t ROP_SLOT_EMPTY = '{rd: 1'b0, wr: 1'b0, off: 1'b1};

    // Map a raw command code onto slot flags
    function automatic rop_slot_t rop_decode(input logic [1:0] code);
        rop_slot_t s;
        s.rd  = (code == CMD_READ);
        s.wr  = (code == CMD_WRITE);
        s.off = !(s.rd || s.wr);
        return s;
    endfunction

endpackage

// File: rtl/rop_cmd_stage.sv
// Input command register. It captures the command of each cycle in decoded form.
// Assumes that cmd is stable around the rising edge. Reset leaves a deselect in the slot.
module rop_cmd_stage
    import rop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_in,
    output rop_slot_t  slot_q
);

    // Capture and decode the incoming command
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= ROP_SLOT_EMPTY;
        else        slot_q <= rop_decode(cmd_in);
    end

endmodule

// File: rtl/rop_data_stage.sv
// Rising-edge output register, organised as one register per byte lane.
// It loads the core word only when the input slot holds a read, so the last read word stays held.
// Assumes that DATA_W is a whole multiple of LANE_W.
module rop_data_stage #(
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_rd,
    input  logic [DATA_W-1:0] core_rdata,
    output logic              s2_rd,
    output logic [DATA_W-1:0] s2_data
);

    localparam int LANES = DATA_W / LANE_W;

    // Track whether the output register holds a read
    always_ff @(posedge clk) begin
        if (!rst_n) s2_rd <= 1'b0;
        else        s2_rd <= s1_rd;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Load one lane of the core word when a read advances
        always_ff @(posedge clk) begin
            if (!rst_n)     s2_data[g*LANE_W +: LANE_W] <= '0;
            else if (s1_rd) s2_data[g*LANE_W +: LANE_W] <= core_rdata[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/rop_drive_ctl.sv
// Pad driver enable. It chooses the read path by mode, applies the deselect rule
// and the write release, and gates the result with the asynchronous active-low output enable.
// Assumes that the slot flags come straight from registers.
module rop_drive_ctl
    import rop_pkg::*;
(
    input  logic      mode_flow,
    input  logic      mode_dcd,
    input  rop_slot_t s1,
    input  logic      s2_rd,
    input  logic      oe_n,
    output logic      drive
);

    logic flow_on;
    logic pipe_on;
    logic early_off;

    // Work out the enable for each path and apply the output enable
    always_comb begin
        flow_on   = s1.rd;
        early_off = s1.wr || (!mode_dcd && s1.off);
        pipe_on   = s2_rd && !early_off;
        drive     = (mode_flow ? flow_on : pipe_on) && !oe_n;
    end

endmodule

// File: rtl/rop_read_out_path.sv
// Top level of the read output path. It chains the command register, the lane output
// register and the drive control, and picks the direct or registered word for each lane.
// Assumes that the mode inputs are static or change only between bursts.
module rop_read_out_path
    import rop_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_flow,
    input  logic              mode_dcd,
    input  logic [1:0]        cmd,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);

    localparam int LANES = DATA_W / LANE_W;

    rop_slot_t         s1;
    logic              s2_rd;
    logic [DATA_W-1:0] s2_data;

    rop_cmd_stage u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_in (cmd),
        .slot_q (s1)
    );

    rop_data_stage #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_rd      (s1.rd),
        .core_rdata (core_rdata),
        .s2_rd      (s2_rd),
        .s2_data    (s2_data)
    );

    rop_drive_ctl u_drv (
        .mode_flow (mode_flow),
        .mode_dcd  (mode_dcd),
        .s1        (s1),
        .s2_rd     (s2_rd),
        .oe_n      (oe_n),
        .drive     (dq_drive)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        // Choose the bypass or the registered word for one lane
        always_comb begin
            dq_out[g*LANE_W +: LANE_W] = mode_flow ? core_rdata[g*LANE_W +: LANE_W]
                                                   : s2_data[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/rop_read_out_chk.sv
// Timing checker for the read output path. It watches the top-level ports only.
// Assumes that the mode inputs are sampled on the same edge as the command.
module rop_read_out_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_flow,
    input logic              mode_dcd,
    input logic [1:0]        cmd,
    input logic [DATA_W-1:0] core_rdata,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive
);

    assert_oe_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);

    assert_write_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10) |=> !dq_drive);

    assert_flow_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flow && cmd == 2'b01) ##1 (mode_flow && !oe_n) |-> (dq_drive && dq_out == core_rdata));

    assert_pipe_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_flow && $past(!mode_flow) && dq_drive) |-> (dq_out == $past(core_rdata)));

    assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b00 || cmd == 2'b11) ##1 (!mode_flow && !mode_dcd) |-> !dq_drive);

    assert_dual_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !mode_flow && mode_dcd) ##1 (cmd != 2'b01 && cmd != 2'b10)
        ##1 (!mode_flow && mode_dcd && !oe_n) |-> dq_drive);

endmodule

bind rop_read_out_path rop_read_out_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_flow  (mode_flow),
    .mode_dcd   (mode_dcd),
    .cmd        (cmd),
    .core_rdata (core_rdata),
    .oe_n       (oe_n),
    .dq_out     (dq_out),
    .dq_drive   (dq_drive)
);

// File: tb/tb_rop_read_out_path.sv
`timescale 1ns/1ps
module tb_rop_read_out_path;

    localparam int CLK_PERIOD = 20;
    localparam int DATA_W     = 36;

    localparam logic [1:0] C_IDLE  = 2'b00;
    localparam logic [1:0] C_READ  = 2'b01;
    localparam logic [1:0] C_WRITE = 2'b10;
    localparam logic [1:0] C_SPARE = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_flow = 1'b0;
    logic              mode_dcd = 1'b0;
    logic [1:0]        cmd = 2'b00;
    logic [DATA_W-1:0] rd_word_in = '0;
    logic [DATA_W-1:0] core_q = '0;
    logic              oe_drv = 1'b0;
    logic              oe_probe = 1'b0;
    logic              oe_n;
    logic [DATA_W-1:0] dq_out;
    logic              dq_drive;

    assign oe_n = oe_drv | oe_probe;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Core model: the word for a read appears in the cycle after its capture
    always @(posedge clk) core_q <= rd_word_in;

    rop_read_out_path #(.DATA_W(DATA_W), .LANE_W(9)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_flow  (mode_flow),
        .mode_dcd   (mode_dcd),
        .cmd        (cmd),
        .core_rdata (core_q),
        .oe_n       (oe_n),
        .dq_out     (dq_out),
        .dq_drive   (dq_drive)
    );

    typedef struct {
        logic              drv;
        logic [DATA_W-1:0] data;
        int                req;
        bit                probe;
    } exp_t;

    exp_t              sb_q[$];
    int                checks = 0;
    int                errors = 0;
    logic [1:0]        prev_cmd = 2'b00;
    logic [DATA_W-1:0] prev_word = '0;
    bit                done = 1'b0;

    task automatic check(input bit ok, input int req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: present one cycle of stimulus and queue the expected output
    task automatic step(input logic [1:0] c, input logic [DATA_W-1:0] w, input logic fl,
                        input logic dc, input logic oe, input int req, input bit probe);
        exp_t it;
        logic rd_n, wr_n, off_n;
        @(negedge clk);
        cmd = c; rd_word_in = w; mode_flow = fl; mode_dcd = dc; oe_drv = oe;
        rd_n  = (c == C_READ);
        wr_n  = (c == C_WRITE);
        off_n = !rd_n && !wr_n;
        if (fl) begin
            it.drv  = rd_n;
            it.data = w;
        end else begin
            it.drv  = (prev_cmd == C_READ) && !wr_n && !(!dc && off_n);
            it.data = prev_word;
        end
        it.drv   = it.drv && !oe;
        it.req   = req;
        it.probe = probe;
        sb_q.push_back(it);
        prev_cmd  = c;
        prev_word = w;
    endtask

    // Monitor: compare each queued expectation a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(dq_drive === it.drv, it.req, "drive", {{(DATA_W-1){1'b0}}, dq_drive},
                      {{(DATA_W-1){1'b0}}, it.drv});
                if (it.drv)
                    check(dq_out === it.data, it.req, "word", dq_out, it.data);
                if (it.probe) begin
                    #1 oe_probe = 1'b1;
                    #1 check(dq_drive === 1'b0, 9, "async oe off", {{(DATA_W-1){1'b0}}, dq_drive}, '0); // R9
                    oe_probe = 1'b0;
                    #1 check(dq_drive === it.drv, 9, "async oe back", {{(DATA_W-1){1'b0}}, dq_drive},
                             {{(DATA_W-1){1'b0}}, it.drv}); // R9
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reads offered during reset must not reach the pads
        rst_n = 1'b0;
        cmd = C_READ;
        repeat (3) @(negedge clk);
        check(dq_drive === 1'b0, 1, "drive in reset", {{(DATA_W-1){1'b0}}, dq_drive}, '0);
        check(dq_out === '0, 1, "word in reset", dq_out, '0);
        cmd = C_IDLE;
        rst_n = 1'b1;
        step(C_IDLE, '0, 0, 0, 0, 1, 0);                          // R1
        step(C_IDLE, '0, 0, 0, 0, 1, 0);                          // R1

        // R10, R3, R4, R5: default modes, burst of four, then release
        step(C_READ, 36'h1_0000_0001, 0, 0, 0, 3, 0);             // R3
        step(C_READ, 36'h2_0000_0002, 0, 0, 0, 4, 0);             // R4
        step(C_READ, 36'h3_0000_0003, 0, 0, 0, 4, 0);             // R4
        step(C_READ, 36'h4_0000_0004, 0, 0, 0, 10, 0);            // R10
        step(C_IDLE, '0, 0, 0, 0, 5, 0);                          // R5
        step(C_IDLE, '0, 0, 0, 0, 5, 0);                          // R5

        // R6: dual-cycle release holds the last word one more cycle
        step(C_READ, 36'hA_5A5A_0001, 0, 1, 0, 3, 0);             // R3
        step(C_READ, 36'hB_5A5A_0002, 0, 1, 0, 4, 0);             // R4
        step(C_IDLE, '0, 0, 1, 0, 6, 1);                          // R6 and R9 probe
        step(C_IDLE, '0, 0, 1, 0, 6, 0);                          // R6
        step(C_IDLE, '0, 0, 1, 0, 6, 0);                          // R6

        // R2, R4, R7: flow-through bursts under both release settings
        step(C_READ, 36'hC_0000_0011, 1, 0, 0, 2, 0);             // R2
        step(C_READ, 36'hC_0000_0012, 1, 0, 0, 4, 0);             // R4
        step(C_IDLE, '0, 1, 0, 0, 7, 0);                          // R7
        step(C_READ, 36'hD_0000_0021, 1, 1, 0, 2, 0);             // R2
        step(C_READ, 36'hD_0000_0022, 1, 1, 1, 9, 0);             // R9: oe high blocks
        step(C_READ, 36'hD_0000_0023, 1, 1, 0, 4, 0);             // R4
        step(C_SPARE, '0, 1, 1, 0, 7, 0);                         // R7
        step(C_IDLE, '0, 1, 1, 0, 7, 0);                          // R7

        // R8: a write releases a pending pipelined word, in dual-cycle mode too
        step(C_READ, 36'hE_0000_0031, 0, 1, 0, 3, 0);             // R3
        step(C_WRITE, '0, 0, 1, 0, 8, 0);                         // R8
        step(C_IDLE, '0, 0, 1, 0, 8, 0);                          // R8
        step(C_READ, 36'hE_0000_0032, 1, 0, 0, 2, 0);             // R2
        step(C_WRITE, '0, 1, 0, 0, 8, 0);                         // R8

        // R10: code 2'b11 acts as a deselect in single-cycle pipelined mode
        step(C_READ, 36'hF_0000_0041, 0, 0, 0, 3, 0);             // R3
        step(C_SPARE, '0, 0, 0, 0, 10, 0);                        // R10
        step(C_READ, 36'hF_0000_0042, 0, 0, 0, 10, 0);            // R10
        step(C_IDLE, '0, 0, 0, 0, 5, 0);                          // R5
        step(C_IDLE, '0, 0, 0, 0, 1, 0);

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule